// File: doc/BRIEF.md
# MAC Hash-Table Address Filter

This block decides whether a received frame is wanted by checking its 48-bit destination MAC address against a table that the host loads. The host fills an internal entry memory through a simple write port. Each entry is 64 bits wide and holds one packed address and three flag bits. For a lookup, the block first bit-reverses the leading address bytes. It then folds them into an 11-bit bucket index and probes the table from that bucket onward, one entry per clock.

A probe stops at the first occupied entry whose address matches, which gives a hit. It also stops at the first entry that is not occupied, which gives a miss. An occupied entry with a different address moves the probe to the next index, wrapping around the end of the table. After twelve probes the lookup ends as a miss. A hit returns the matched entry's receive/discard-select flag. When the promiscuous control is set, every request is accepted at once, without touching the table.

The receive path raises a request while the block is idle and waits for the one-cycle `done_o` pulse. It then reads `hit_o` and `rd_sel_o`, which hold their values until the next result.

Top module: `mac_hash_filter`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge), busy_o, done_o, hit_o and rd_sel_o are all 0, and every table entry reads as empty.
- R2: The address is byte 0 in look_addr_i[47:40] through byte 5 in look_addr_i[7:0]. Each of bytes 0..4 is bit-reversed to give g0..g4. The value is computed as (g0[7:2] << 7) OR ({g1[6:0],g0[1:0]} XOR {g2,g1[7]} XOR {g4[0],g3}). The first probed index is the low 11 bits of that value.
- R3: An entry is hi = tbl_hi_i and lo = tbl_lo_i. The upper word holds the flags as valid at bit 0, skip at bit 1 and select at bit 2. It also holds byte 5 at [10:3], byte 4 at [18:11], byte 3 at [26:19] and byte 2 bits 4:0 at [31:27]. The lower word holds byte 2 bits 7:5 at [2:0], byte 1 at [10:3] and byte 0 at [18:11]. A hit needs all 48 address bits to be equal.
- R4: An entry is occupied only when valid is 1 and skip is 0. Probing an entry that is not occupied ends the lookup as a miss, even if its address bits match.
- R5: An occupied entry with a different address moves the probe to the next index, modulo 2048, so index 2047 is followed by index 0.
- R6: At most 12 entries are probed. If the twelfth probed entry is occupied but does not match, the result is a miss.
- R7: On a hit, rd_sel_o equals the matched entry's select flag. On a miss, hit_o and rd_sel_o are both 0.
- R8: Suppose a request is accepted at clock edge E and the lookup probes k entries. Then done_o is 1 for exactly the one cycle that follows edge E+k, and busy_o is 1 from edge E through that cycle.
- R9: A request accepted while promiscuous_i is 1 probes nothing. It gives done_o in the cycle after the accepting edge, with hit_o = 1 and rd_sel_o = 0.
- R10: A request is accepted only while busy_o is 0. Requests raised during probing or during the done cycle are ignored and change neither the result nor busy_o.
- R11: A table write takes effect at the clock edge that samples it. A probe evaluated in the cycle ending at that edge still sees the old contents, and later probes see the new contents.
- R12: hit_o and rd_sel_o change only in the cycle where done_o is 1, and hold their values otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, all logic on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| promiscuous_i | input | 1 | Accept every request without looking up the table |
| tbl_wr_i | input | 1 | Write strobe for one table entry |
| tbl_idx_i | input | IDX_W (11) | Entry index written |
| tbl_hi_i | input | 32 | Upper word of the written entry (flags and bytes 2..5) |
| tbl_lo_i | input | 32 | Lower word of the written entry (bytes 0..2) |
| look_req_i | input | 1 | Lookup request, taken when idle |
| look_addr_i | input | 48 | Destination address of the request |
| busy_o | output | 1 | Lookup in progress, including the done cycle |
| done_o | output | 1 | One-cycle result strobe |
| hit_o | output | 1 | Last result: address accepted |
| rd_sel_o | output | 1 | Last result: select flag of the matched entry |

## Verification
A host write and a probe can land in the same cycle. The bench forces this by issuing a write on the cycle right after a request is accepted. In one case the write targets the entry being probed, and in the other it targets the next entry in the chain. The ordering rule then gives a miss in the first case and a two-probe hit in the second. A new request can also coincide with a probe or with the done cycle. The bench holds the request line high with a different address through a whole lookup, and then checks that the result belongs to the first address and that busy_o drops. A behavioural model that steps every clock judges all outputs, and explicit checks against hand-derived hit, select and probe counts back it up.

// File: rtl/mhf_pkg.sv
// Shared constants and types for the MAC hash-table address filter.
// Assumes a 48-bit address and 64-bit table entries split into two words.
package mhf_pkg;
    localparam int MAC_W     = 48;
    localparam int WORD_W    = 32;
    localparam int FLG_VALID = 0;
    localparam int FLG_SKIP  = 1;
    localparam int FLG_SEL   = 2;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_PROBE = 2'd1,
        PH_DONE  = 2'd2
    } phase_t;

    typedef struct packed {
        logic [WORD_W-1:0] hi;
        logic [WORD_W-1:0] lo;
    } entry_t;
endpackage

// File: rtl/mhf_hash.sv
// Bucket hash: bit-reverses address bytes 0..4 and folds them into an
// index. Purely combinational. Assumes IDX_W is at most 13.
module mhf_hash
    import mhf_pkg::*;
#(
    parameter int IDX_W = 11
) (
    input  logic [MAC_W-1:0] mac_i,
    output logic [IDX_W-1:0] bucket_o
);
    localparam int NB     = 5;
    localparam int FOLD_W = 9;
    localparam int FULL_W = 13;

    logic [NB-1:0][7:0] rev;
    logic [FOLD_W-1:0]  fold;
    logic [FULL_W-1:0]  full;
    logic               unused_hash_bits;

    // Bit reversal of each leading byte (byte k sits at mac_i[47-8k -: 8]).
    for (genvar k = 0; k < NB; k++) begin : g_byte
        for (genvar b = 0; b < 8; b++) begin : g_bit
            assign rev[k][b] = mac_i[MAC_W-1-8*k-b];
        end
    end

    // XOR fold of the reversed bytes, merged with the top bits of byte 0.
    always_comb begin
        fold     = {rev[1][6:0], rev[0][1:0]} ^ {rev[2], rev[1][7]} ^ {rev[4][0], rev[3]};
        full     = {rev[0][7:2], 7'b0} | {{(FULL_W-FOLD_W){1'b0}}, fold};
        bucket_o = full[IDX_W-1:0];
    end

    assign unused_hash_bits = ^{full, rev[4][7:1], mac_i[7:0]};
endmodule

// File: rtl/mhf_table.sv
// Entry memory with one write port and one asynchronous read port.
// A per-entry loaded bit, cleared by reset, makes unwritten entries read as
// zero (empty) without a clearing sequence.
module mhf_table
    import mhf_pkg::*;
#(
    parameter int IDX_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en_i,
    input  logic [IDX_W-1:0] wr_idx_i,
    input  entry_t           wr_entry_i,
    input  logic [IDX_W-1:0] rd_idx_i,
    output entry_t           rd_entry_o
);
    localparam int DEPTH = 1 << IDX_W;

    entry_t           mem [DEPTH];
    logic [DEPTH-1:0] loaded_q;

    // Storage array: written by the host, not reset.
    always_ff @(posedge clk) begin
        if (wr_en_i) begin
            mem[wr_idx_i] <= wr_entry_i;
        end
    end

    // Loaded markers: reset to empty, set on each write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            loaded_q <= '0;
        end else if (wr_en_i) begin
            loaded_q[wr_idx_i] <= 1'b1;
        end
    end

    // Read port: entries never written read as all zero.
    assign rd_entry_o = loaded_q[rd_idx_i] ? mem[rd_idx_i] : '0;

    // R11: a written entry is non-empty on the read port right after the write.
    assert_write_lands_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && wr_entry_i[WORD_W+FLG_VALID] && rd_idx_i == wr_idx_i)
        |=> ($past(rd_idx_i) != rd_idx_i) || rd_entry_o[WORD_W+FLG_VALID]);
endmodule

// File: rtl/mhf_match.sv
// Entry decoder: unpacks the stored address from the two words, reports
// occupancy (valid set, skip clear) and a full 48-bit match. Combinational.
module mhf_match
    import mhf_pkg::*;
(
    input  entry_t           ent_i,
    input  logic [MAC_W-1:0] mac_i,
    output logic             occupied_o,
    output logic             match_o,
    output logic             sel_o
);
    logic [MAC_W-1:0] stored;
    logic             unused_lo_bits;

    // Reassemble bytes 0..5 from their packed field positions.
    always_comb begin
        stored     = {ent_i.lo[18:11], ent_i.lo[10:3], ent_i.lo[2:0], ent_i.hi[31:27],
                      ent_i.hi[26:19], ent_i.hi[18:11], ent_i.hi[10:3]};
        occupied_o = ent_i.hi[FLG_VALID] && !ent_i.hi[FLG_SKIP];
        match_o    = occupied_o && (stored == mac_i);
        sel_o      = ent_i.hi[FLG_SEL];
    end

    assign unused_lo_bits = ^ent_i.lo[WORD_W-1:19];
endmodule

// File: rtl/mac_hash_filter.sv
// MAC hash-table address filter, top level. Accepts a lookup while idle,
// hashes the address to a bucket, probes one entry per clock for a bounded
// number of hops, and pulses done_o one cycle after the deciding edge.
// Assumes the requester holds look_addr_i valid with look_req_i.
module mac_hash_filter
    import mhf_pkg::*;
#(
    parameter int IDX_W     = 11,
    parameter int HOP_LIMIT = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             promiscuous_i,
    input  logic             tbl_wr_i,
    input  logic [IDX_W-1:0] tbl_idx_i,
    input  logic [31:0]      tbl_hi_i,
    input  logic [31:0]      tbl_lo_i,
    input  logic             look_req_i,
    input  logic [47:0]      look_addr_i,
    output logic             busy_o,
    output logic             done_o,
    output logic             hit_o,
    output logic             rd_sel_o
);
    localparam int HOP_W = $clog2(HOP_LIMIT);
    localparam logic [HOP_W-1:0] HOP_LAST = HOP_W'(HOP_LIMIT - 1);

    phase_t           phase_q;
    logic [IDX_W-1:0] idx_q;
    logic [HOP_W-1:0] hop_q;
    logic [MAC_W-1:0] mac_q;
    logic             hit_q;
    logic             sel_q;
    logic [IDX_W-1:0] bucket;
    entry_t           probe_ent;
    entry_t           wr_ent;
    logic             occupied;
    logic             matched;
    logic             ent_sel;

    assign wr_ent = '{hi: tbl_hi_i, lo: tbl_lo_i};

    mhf_hash #(.IDX_W(IDX_W)) u_hash (
        .mac_i    (look_addr_i),
        .bucket_o (bucket)
    );

    mhf_table #(.IDX_W(IDX_W)) u_table (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en_i    (tbl_wr_i),
        .wr_idx_i   (tbl_idx_i),
        .wr_entry_i (wr_ent),
        .rd_idx_i   (idx_q),
        .rd_entry_o (probe_ent)
    );

    mhf_match u_match (
        .ent_i      (probe_ent),
        .mac_i      (mac_q),
        .occupied_o (occupied),
        .match_o    (matched),
        .sel_o      (ent_sel)
    );

    // Lookup sequencer: accept, probe with hop bound and wrap, report.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
            idx_q   <= '0;
            hop_q   <= '0;
            mac_q   <= '0;
            hit_q   <= 1'b0;
            sel_q   <= 1'b0;
        end else begin
            unique case (phase_q)
                PH_IDLE: begin
                    if (look_req_i) begin
                        mac_q <= look_addr_i;
                        if (promiscuous_i) begin
                            phase_q <= PH_DONE;
                            hit_q   <= 1'b1;
                            sel_q   <= 1'b0;
                        end else begin
                            phase_q <= PH_PROBE;
                            idx_q   <= bucket;
                            hop_q   <= '0;
                        end
                    end
                end
                PH_PROBE: begin
                    if (matched) begin
                        phase_q <= PH_DONE;
                        hit_q   <= 1'b1;
                        sel_q   <= ent_sel;
                    end else if (!occupied || hop_q == HOP_LAST) begin
                        phase_q <= PH_DONE;
                        hit_q   <= 1'b0;
                        sel_q   <= 1'b0;
                    end else begin
                        idx_q <= idx_q + IDX_W'(1);
                        hop_q <= hop_q + HOP_W'(1);
                    end
                end
                PH_DONE: phase_q <= PH_IDLE;
                default: phase_q <= PH_IDLE;
            endcase
        end
    end

    assign busy_o   = (phase_q != PH_IDLE);
    assign done_o   = (phase_q == PH_DONE);
    assign hit_o    = hit_q;
    assign rd_sel_o = sel_q;

    // R8: the result strobe lasts a single cycle.
    assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R6: the last permitted probe always ends the lookup.
    assert_hop_stop_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_PROBE && hop_q == HOP_LAST) |=> done_o);

    // R4: an entry that is not occupied ends the lookup as a miss.
    assert_empty_miss_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_PROBE && !occupied) |=> (done_o && !hit_o && !rd_sel_o));

    // R9: promiscuous acceptance reports a hit on the next cycle.
    assert_promisc_accept_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && look_req_i && promiscuous_i) |=> (done_o && hit_o && !rd_sel_o));

    // R10: work starts only from a request seen while idle.
    assert_start_on_req_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> $past(look_req_i));

    // R12: results hold outside the strobe cycle.
    assert_result_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> ($stable(hit_o) && $stable(rd_sel_o)));
endmodule

// File: tb/mac_hash_filter_test.sv
module mac_hash_filter_test;
    localparam int DEPTH = 2048;
    localparam int HOPS  = 12;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        promisc = 1'b0;
    logic        tbl_wr = 1'b0;
    logic [10:0] tbl_idx = '0;
    logic [31:0] tbl_hi = '0;
    logic [31:0] tbl_lo = '0;
    logic        look_req = 1'b0;
    logic [47:0] look_addr = '0;
    logic        busy, done, hit, rd_sel;

    int    n_cmp = 0;
    int    n_bad = 0;
    string cur_tag = "R1";

    always #5 clk = ~clk;

    mac_hash_filter uut (
        .clk(clk), .rst_n(rst_n), .promiscuous_i(promisc),
        .tbl_wr_i(tbl_wr), .tbl_idx_i(tbl_idx), .tbl_hi_i(tbl_hi), .tbl_lo_i(tbl_lo),
        .look_req_i(look_req), .look_addr_i(look_addr),
        .busy_o(busy), .done_o(done), .hit_o(hit), .rd_sel_o(rd_sel)
    );

    function automatic int rev8(int v);
        int r = 0;
        for (int b = 0; b < 8; b++) if (((v >> b) & 1) != 0) r |= (1 << (7 - b));
        return r;
    endfunction

    function automatic int bucket_of(logic [47:0] a);
        int g[5];
        int v, t;
        for (int k = 0; k < 5; k++) g[k] = rev8(int'((a >> (40 - 8 * k)) & 48'hFF));
        v = ((g[0] >> 2) & 63) << 7;
        t = (g[0] & 3) | ((g[1] & 127) << 2);
        t = t ^ (((g[1] >> 7) & 1) | (g[2] << 1));
        t = t ^ (g[3] | ((g[4] & 1) << 8));
        return (v | t) & 2047;
    endfunction

    function automatic logic [63:0] entry_of(logic [47:0] a, bit v, bit s, bit sel);
        logic [31:0] by[6];
        logic [31:0] hi, lo;
        for (int k = 0; k < 6; k++) by[k] = 32'((a >> (40 - 8 * k)) & 48'hFF);
        hi = 32'(v) | (32'(s) << 1) | (32'(sel) << 2) | (by[5] << 3) | (by[4] << 11)
           | (by[3] << 19) | ((by[2] & 32'd31) << 27);
        lo = ((by[2] >> 5) & 32'd7) | (by[1] << 3) | (by[0] << 11);
        return {hi, lo};
    endfunction

    function automatic logic [47:0] addr_in(logic [63:0] e);
        logic [31:0] hi, lo;
        logic [7:0]  b[6];
        hi = e[63:32];
        lo = e[31:0];
        b[5] = 8'((hi >> 3) & 32'hFF);
        b[4] = 8'((hi >> 11) & 32'hFF);
        b[3] = 8'((hi >> 19) & 32'hFF);
        b[2] = 8'((((lo & 32'd7) << 5) | ((hi >> 27) & 32'd31)));
        b[1] = 8'((lo >> 3) & 32'hFF);
        b[0] = 8'((lo >> 11) & 32'hFF);
        return {b[0], b[1], b[2], b[3], b[4], b[5]};
    endfunction

    // Behavioural reference, stepped on every rising edge.
    logic [63:0] tbl [int];
    int          m_phase = 0;
    int          m_idx = 0;
    int          m_hops = 0;
    logic [47:0] m_addr = '0;
    bit          e_hit = 0, e_sel = 0;
    logic [63:0] m_e;
    bit          m_occ;

    always @(posedge clk) begin
        if (!rst_n) begin
            tbl.delete();
            m_phase = 0;
            e_hit = 0;
            e_sel = 0;
        end else begin
            if (m_phase == 0) begin
                if (look_req) begin
                    if (promisc) begin
                        m_phase = 2; e_hit = 1; e_sel = 0;
                    end else begin
                        m_phase = 1; m_idx = bucket_of(look_addr); m_hops = 0; m_addr = look_addr;
                    end
                end
            end else if (m_phase == 1) begin
                m_e = tbl.exists(m_idx) ? tbl[m_idx] : 64'd0;
                m_occ = m_e[32] && !m_e[33];
                if (m_occ && addr_in(m_e) == m_addr) begin
                    m_phase = 2; e_hit = 1; e_sel = m_e[34];
                end else if (!m_occ || m_hops == HOPS - 1) begin
                    m_phase = 2; e_hit = 0; e_sel = 0;
                end else begin
                    m_idx = (m_idx + 1) % DEPTH; m_hops++;
                end
            end else begin
                m_phase = 0;
            end
            if (tbl_wr) tbl[int'(tbl_idx)] = {tbl_hi, tbl_lo};
        end
    end

    // Per-cycle comparison against the reference.
    always @(negedge clk) begin
        if (rst_n) begin
            n_cmp++;
            if ({busy, done, hit, rd_sel} !== {m_phase != 0, m_phase == 2, e_hit, e_sel}) begin
                n_bad++;
                $display("FAIL %s cycle compare busy/done/hit/sel: actual %b expected %b", cur_tag,
                         {busy, done, hit, rd_sel}, {m_phase != 0, m_phase == 2, e_hit, e_sel});
            end
        end
    end

    task automatic check(bit ok, string tag, string what, int act, int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic put(int idx, logic [63:0] e);
        @(negedge clk);
        tbl_wr = 1'b1; tbl_idx = 11'(idx); tbl_hi = e[63:32]; tbl_lo = e[31:0];
        @(negedge clk);
        tbl_wr = 1'b0;
    endtask

    task automatic wipe(int start, int n);
        for (int i = 0; i < n; i++) put((start + i) % DEPTH, 64'd0);
    endtask

    int          pend_idx = 0;
    logic [63:0] pend_e = '0;

    // mode 0: plain; 1: write pend_e at pend_idx one cycle after accept;
    // 2: hold the request with another address through the lookup.
    task automatic lookup(logic [47:0] a, bit exp_hit, bit exp_sel, int exp_probes,
                          string tag, int mode);
        int n;
        cur_tag = tag;
        @(negedge clk);
        look_req = 1'b1; look_addr = a;
        @(negedge clk);
        n = 1;
        if (mode == 2) look_addr = a ^ 48'h00FF_0000_0001;
        else look_req = 1'b0;
        if (mode == 1) begin
            tbl_wr = 1'b1; tbl_idx = 11'(pend_idx); tbl_hi = pend_e[63:32]; tbl_lo = pend_e[31:0];
        end
        while (!done && n < 40) begin
            @(negedge clk);
            tbl_wr = 1'b0;
            n++;
        end
        tbl_wr = 1'b0;
        check(done == 1'b1, tag, "done seen", int'(done), 1);
        check(n == exp_probes + 1, tag, "R8 cycles to done", n, exp_probes + 1);
        check(hit == exp_hit, tag, "hit", int'(hit), int'(exp_hit));
        check(rd_sel == exp_sel, tag, "select", int'(rd_sel), int'(exp_sel));
        @(negedge clk);
        check(done == 1'b0, tag, "R8 single done pulse", int'(done), 0);
        if (mode == 2) check(busy == 1'b0, "R10", "busy after ignored request", int'(busy), 0);
        look_req = 1'b0;
    endtask

    logic [47:0] addr_a, addr_w;
    int          b_a, found;

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        addr_a = 48'h3CA5_10E7_4299;
        b_a = bucket_of(addr_a);
        repeat (3) @(negedge clk);
        check({busy, done, hit, rd_sel} == 4'b0, "R1", "outputs in reset", int'({busy, done, hit, rd_sel}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check({busy, done, hit, rd_sel} == 4'b0, "R1", "outputs after reset", int'({busy, done, hit, rd_sel}), 0);

        // Empty table: single probe miss.
        lookup(addr_a, 0, 0, 1, "R4", 0);

        // Entry at its bucket, select 1 then 0.
        put(b_a, entry_of(addr_a, 1, 0, 1));
        lookup(addr_a, 1, 1, 1, "R2", 0);
        put(b_a, entry_of(addr_a, 1, 0, 0));
        lookup(addr_a, 1, 0, 1, "R7", 0);
        repeat (3) @(negedge clk);
        check(hit == 1'b1 && rd_sel == 1'b0, "R12", "result held", int'({hit, rd_sel}), 2);

        // Collision chain of three.
        put(b_a, entry_of(addr_a ^ 48'h1, 1, 0, 0));
        put((b_a + 1) % DEPTH, entry_of(addr_a ^ 48'h2, 1, 0, 0));
        put((b_a + 2) % DEPTH, entry_of(addr_a, 1, 0, 1));
        lookup(addr_a, 1, 1, 3, "R5", 0);

        // Skip flag and cleared valid flag end the chain.
        put((b_a + 1) % DEPTH, entry_of(addr_a, 1, 1, 1));
        lookup(addr_a, 0, 0, 2, "R4", 0);
        put(b_a, entry_of(addr_a, 0, 0, 1));
        lookup(addr_a, 0, 0, 1, "R4", 0);

        // Near matches that differ in the split byte-2 field.
        wipe(b_a, 4);
        put(b_a, entry_of(addr_a ^ 48'h0000_2000_0000, 1, 0, 1));
        put((b_a + 1) % DEPTH, entry_of(addr_a ^ 48'h0000_0100_0000, 1, 0, 1));
        lookup(addr_a, 0, 0, 3, "R3", 0);

        // Hop limit.
        for (int i = 0; i < HOPS; i++) put((b_a + i) % DEPTH, entry_of(addr_a ^ 48'(i + 16), 1, 0, 0));
        put((b_a + HOPS) % DEPTH, entry_of(addr_a, 1, 0, 1));
        lookup(addr_a, 0, 0, 12, "R6", 0);
        put((b_a + HOPS - 1) % DEPTH, entry_of(addr_a, 1, 0, 1));
        lookup(addr_a, 1, 1, 12, "R6", 0);
        wipe(b_a, HOPS + 1);

        // Wrap from the last index to index 0.
        found = 0;
        addr_w = '0;
        for (int v = 0; v < 256 && found == 0; v++) begin
            addr_w = {8'hFF, 8'h00, 8'h00, 8'(v), 8'h00, 8'h12};
            if (bucket_of(addr_w) == DEPTH - 1) found = 1;
        end
        check(found == 1, "R2", "address with last bucket", found, 1);
        put(DEPTH - 1, entry_of(addr_w ^ 48'h4, 1, 0, 0));
        put(0, entry_of(addr_w, 1, 0, 1));
        lookup(addr_w, 1, 1, 2, "R5", 0);

        // Promiscuous acceptance of an address absent from the table.
        promisc = 1'b1;
        lookup(48'hA0B0_C0D0_E0F0, 1, 0, 0, "R9", 0);
        promisc = 1'b0;

        // Request held high during a lookup.
        lookup(addr_w, 1, 1, 2, "R10", 2);

        // Write in the cycle right after acceptance.
        put(b_a, entry_of(addr_a ^ 48'h8, 1, 0, 0));
        put((b_a + 1) % DEPTH, 64'd0);
        pend_idx = (b_a + 1) % DEPTH;
        pend_e = entry_of(addr_a, 1, 0, 1);
        lookup(addr_a, 1, 1, 2, "R11", 1);
        put((b_a + 1) % DEPTH, 64'd0);
        pend_idx = b_a;
        lookup(addr_a, 0, 0, 2, "R11", 1);
        lookup(addr_a, 1, 1, 1, "R11", 0);

        repeat (2) @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule